// File: doc/BRIEF.md
# Coherent Port Snoop/DVM Enable Controller

This block sits beside the slave interfaces of a coherent interconnect and decides, for each interface, whether snoop requests and distributed-virtual-memory (DVM) requests may flow through it. Software programs each interface through its own control register on a small memory-mapped register bus. The block does not switch traffic itself. It drives a two-bit request-enable value to the port-side logic and waits for that logic to confirm the change.

Each interface has a control register at offset 0x0 of its own register window. Bit 0 of that register enables snoop requests and bit 1 enables DVM requests. Writing 0x3 turns both on and writing 0x0 turns both off. A change is complete only when the port returns an acknowledge that carries the value that was requested. Until every outstanding change is acknowledged, bit 0 of a global status register reads 1, and software polls that bit until it reads 0.

The default build has five slave interfaces: two full-coherency interfaces and three I/O-coherent lite interfaces. The window for interface i (counting from 0) starts at byte address (i+1)·0x1000. The global status register is at address 0x00C, which lies in window 0. The bus carries no payload stream, so it is a plain one-cycle write strobe with a combinational read path and no back-pressure. A write takes effect at the clock edge on which `bus_wr` is sampled high. `bus_rdata` always reflects `bus_addr` in the same cycle.

Top module: `snpdvm_gate_ctrl`

## Requirements
- R1: After reset, every interface control register reads 0, every request-enable output pair is 0 (snoop and DVM off), and the status register reads 0.
- R2: A write to offset 0x0 of window i+1 stores `bus_wdata[1:0]` (bit 0 snoop, bit 1 DVM). A read of that address returns the stored bits in `bus_rdata[1:0]`, with all higher bits 0.
- R3: A write whose value differs from the interface's stored value, made while that interface has no change pending, drives the new value on `port_req_en[2i+1:2i]` from the next clock edge on. It also marks the interface pending, so status bit 0 (address 0x00C) reads 1.
- R4: A write whose value equals the interface's stored value does not mark the interface pending and does not change its request-enable outputs.
- R5: A pending interface stays pending until a cycle in which `port_ack[i]` is 1 and `port_ack_en[2i+1:2i]` equals the requested value. An acknowledge carrying any other value, or arriving while nothing is pending, has no effect.
- R6: Status bit 0 is 1 exactly while at least one interface is pending. Every other status bit reads 0.
- R7: A write to a pending interface is accepted into its control register at once, but the request-enable outputs hold their value until the matching acknowledge. On that acknowledge, if the stored value differs from the one just acknowledged, the stored value is requested at once and the interface stays pending. Otherwise the interface leaves the pending state.
- R8: Reads of any other address return 0. Writes to any other address change no control register, output or pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wdata | input | 2 | Write data, enable field (bit 0 snoop, bit 1 DVM) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| port_req_en | output | 10 | Requested enables, two bits per interface, interface i at [2i+1:2i] |
| port_ack | input | 5 | Acknowledge strobe, one per interface |
| port_ack_en | input | 10 | Enable value the port confirms, two bits per interface |

## Verification
A stale requested value or a pending flag that is set or cleared wrongly shows up within one clock edge. It appears either on `port_req_en` or as a wrong status bit on the next poll. The bench therefore compares both against a cycle-level model on every cycle. A lost re-request after a write to a pending interface is more hidden: it shows only after the matching acknowledge, as outputs that never reach the last written value. Mismatched acknowledges and writes that store an unchanged value are placed on purpose to expose flags that clear or set on the wrong condition.

// File: rtl/snpdvm_pkg.sv
package snpdvm_pkg;
  localparam int EN_W        = 2;
  localparam int OFS_CTRL    = 'h0;
  localparam int OFS_STATUS  = 'hC;
  typedef logic [EN_W-1:0] en_t;
endpackage

// File: rtl/snpdvm_port_slot.sv
module snpdvm_port_slot
  import snpdvm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_sel,
  input  en_t  wr_val,
  input  logic ack_i,
  input  en_t  ack_en_i,
  output en_t  ctrl_o,
  output en_t  req_o,
  output logic pend_o
);
  en_t  ctrl_q, req_q;
  logic pend_q;
  en_t  ctrl_nx;
  logic ack_ok;

  assign ctrl_nx = wr_sel ? wr_val : ctrl_q;
  assign ack_ok  = pend_q && ack_i && (ack_en_i == req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      req_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nx;
      if (pend_q) begin
        if (ack_ok) begin
          if (ctrl_nx != req_q) begin
            req_q <= ctrl_nx;
          end else begin
            pend_q <= 1'b0;
          end
        end
      end else if (wr_sel && (wr_val != ctrl_q)) begin
        req_q  <= wr_val;
        pend_q <= 1'b1;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign req_o  = req_q;
  assign pend_o = pend_q;

  // R3
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(wr_sel));
  // R5
  pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(ack_i && (ack_en_i == req_q)));
  // R7
  req_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(req_q) |-> $past(wr_sel || ack_i));
  // R4
  idle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> (req_q == ctrl_q));
endmodule

// File: rtl/snpdvm_reg_decode.sv
module snpdvm_reg_decode
  import snpdvm_pkg::*;
#(
  parameter int NPORT     = 5,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int WIN_SHIFT = 12
) (
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [NPORT*EN_W-1:0] slot_ctrl,
  input  logic                  any_pend,
  output logic [NPORT-1:0]      wr_sel,
  output logic [DATA_W-1:0]     rdata
);
  localparam int WIN_W = ADDR_W - WIN_SHIFT;

  logic [WIN_W-1:0]     win;
  logic [WIN_SHIFT-1:0] ofs;

  assign win = bus_addr[ADDR_W-1:WIN_SHIFT];
  assign ofs = bus_addr[WIN_SHIFT-1:0];

  always_comb begin
    wr_sel = '0;
    rdata  = '0;
    if (win == '0 && ofs == WIN_SHIFT'(OFS_STATUS)) begin
      rdata[0] = any_pend;
    end
    for (int i = 0; i < NPORT; i++) begin
      if (win == WIN_W'(i + 1) && ofs == WIN_SHIFT'(OFS_CTRL)) begin
        wr_sel[i]       = bus_wr;
        rdata[EN_W-1:0] = slot_ctrl[i*EN_W +: EN_W];
      end
    end
  end
endmodule

// File: rtl/snpdvm_gate_ctrl.sv
module snpdvm_gate_ctrl
  import snpdvm_pkg::*;
#(
  parameter int NUM_FULL  = 2,
  parameter int NUM_LITE  = 3,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int WIN_SHIFT = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [EN_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  output logic [(NUM_FULL+NUM_LITE)*EN_W-1:0] port_req_en,
  input  logic [NUM_FULL+NUM_LITE-1:0]    port_ack,
  input  logic [(NUM_FULL+NUM_LITE)*EN_W-1:0] port_ack_en
);
  localparam int NPORT = NUM_FULL + NUM_LITE;

  logic [NPORT-1:0]      wr_sel;
  logic [NPORT-1:0]      pend;
  logic [NPORT*EN_W-1:0] slot_ctrl;
  logic                  any_pend;

  assign any_pend = |pend;

  snpdvm_reg_decode #(
    .NPORT(NPORT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_SHIFT(WIN_SHIFT)
  ) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .slot_ctrl(slot_ctrl),
    .any_pend (any_pend),
    .wr_sel   (wr_sel),
    .rdata    (bus_rdata)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_slot
    snpdvm_port_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (wr_sel[g]),
      .wr_val  (bus_wdata),
      .ack_i   (port_ack[g]),
      .ack_en_i(port_ack_en[g*EN_W +: EN_W]),
      .ctrl_o  (slot_ctrl[g*EN_W +: EN_W]),
      .req_o   (port_req_en[g*EN_W +: EN_W]),
      .pend_o  (pend[g])
    );
  end
endmodule

// File: tb/test_snpdvm_gate_ctrl.sv
`timescale 1ns/1ps
module test_snpdvm_gate_ctrl;
  localparam int N = 5;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2*N-1:0] port_req_en;
  logic [N-1:0]   port_ack = '0;
  logic [2*N-1:0] port_ack_en = '0;

  int checks = 0, failures = 0, cyc = 0;
  logic [1:0] m_ctrl [N];
  logic [1:0] m_req  [N];
  bit         m_pend [N];

  always #4 clk = ~clk;

  snpdvm_gate_ctrl i_snpdvm_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_req_en(port_req_en),
    .port_ack(port_ack), .port_ack_en(port_ack_en)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [15:0] a);
    int w;
    w = int'(a[15:12]);
    if (w == 0 && a[11:0] == 12'hC) begin
      exp_rd = '0;
      for (int i = 0; i < N; i++) if (m_pend[i]) exp_rd = 32'd1;
    end else if (w >= 1 && w <= N && a[11:0] == 12'h0) exp_rd = {30'd0, m_ctrl[w-1]};
    else exp_rd = '0;
  endfunction

  function automatic logic [2*N-1:0] exp_req();
    for (int i = 0; i < N; i++) exp_req[2*i +: 2] = m_req[i];
  endfunction

  function automatic logic [15:0] port_addr(input int p);
    port_addr = 16'((p + 1) << 12);
  endfunction

  // advance one cycle with given inputs; update model; compare outputs
  task automatic tick(input bit wr, input logic [15:0] a, input logic [1:0] wd,
                      input logic [N-1:0] ak, input logic [2*N-1:0] ake, input string tag);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; port_ack = ak; port_ack_en = ake;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      logic [1:0] nx;
      bit sel;
      sel = wr && a == port_addr(i);
      nx  = sel ? wd : m_ctrl[i];
      if (m_pend[i]) begin
        if (ak[i] && ake[2*i +: 2] == m_req[i]) begin
          if (nx != m_req[i]) m_req[i] = nx;
          else m_pend[i] = 0;
        end
      end else if (sel && wd != m_ctrl[i]) begin
        m_req[i] = wd; m_pend[i] = 1;
      end
      m_ctrl[i] = nx;
    end
    @(negedge clk);
    bus_wr = 0; port_ack = '0; port_ack_en = '0;
    check(port_req_en == exp_req(), tag, 32'(port_req_en), 32'(exp_req()));
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    bus_wr = 0; bus_addr = a;
    #1;
    check(bus_rdata == exp_rd(a), tag, bus_rdata, exp_rd(a));
  endtask

  task automatic idle(input string tag);
    tick(0, 16'h0, 2'b0, '0, '0, tag);
  endtask

  task automatic ack_port(input int p, input logic [1:0] v, input string tag);
    logic [N-1:0] ak;
    logic [2*N-1:0] ake;
    ak = '0; ake = '0;
    ak[p] = 1'b1; ake[2*p +: 2] = v;
    tick(0, 16'h0, 2'b0, ak, ake, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin m_ctrl[i] = 0; m_req[i] = 0; m_pend[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(port_req_en == '0, "R1 req_en", 32'(port_req_en), 0);
    rd(16'h000C, "R1 status");
    for (int i = 0; i < N; i++) rd(port_addr(i), "R1 ctrl");

    // R2 / R3 enable both on port 0
    tick(1, port_addr(0), 2'b11, '0, '0, "R3 req drive");
    check(port_req_en[1:0] == 2'b11, "R3 value", 32'(port_req_en[1:0]), 3);
    rd(port_addr(0), "R2 readback");
    check(bus_rdata == 32'd3, "R2 direct", bus_rdata, 3);
    rd(16'h000C, "R3 status set");
    check(bus_rdata == 32'd1, "R3 status one", bus_rdata, 1);

    // R5 mismatched ack ignored
    ack_port(0, 2'b01, "R5 bad ack");
    rd(16'h000C, "R5 still pending");
    check(bus_rdata == 32'd1, "R5 mismatch kept", bus_rdata, 1);
    ack_port(0, 2'b11, "R5 good ack");
    rd(16'h000C, "R5 cleared");
    check(bus_rdata == 32'd0, "R5 zero", bus_rdata, 0);

    // R4 unchanged write
    tick(1, port_addr(0), 2'b11, '0, '0, "R4 same write");
    rd(16'h000C, "R4 no pend");
    check(bus_rdata == 32'd0, "R4 status zero", bus_rdata, 0);

    // R6 two ports pending, OR
    tick(1, port_addr(1), 2'b01, '0, '0, "R6 p1");
    tick(1, port_addr(4), 2'b10, '0, '0, "R6 p4");
    ack_port(1, 2'b01, "R6 ack p1");
    rd(16'h000C, "R6 one left");
    check(bus_rdata == 32'd1, "R6 or holds", bus_rdata, 1);
    ack_port(4, 2'b10, "R6 ack p4");
    rd(16'h000C, "R6 all clear");

    // R7 write during pending: re-request after ack
    tick(1, port_addr(2), 2'b01, '0, '0, "R7 first");
    tick(1, port_addr(2), 2'b10, '0, '0, "R7 second");
    check(port_req_en[5:4] == 2'b01, "R7 held", 32'(port_req_en[5:4]), 1);
    rd(port_addr(2), "R7 accepted");
    ack_port(2, 2'b01, "R7 reissue");
    check(port_req_en[5:4] == 2'b10, "R7 latest", 32'(port_req_en[5:4]), 2);
    rd(16'h000C, "R7 still busy");
    ack_port(2, 2'b10, "R7 final ack");
    rd(16'h000C, "R7 done");

    // R8 unmapped addresses
    tick(1, 16'h6000, 2'b11, '0, '0, "R8 high window");
    tick(1, 16'h1004, 2'b11, '0, '0, "R8 bad offset");
    tick(1, 16'h000C, 2'b11, '0, '0, "R8 status write");
    rd(16'h6000, "R8 read hole");
    rd(16'h1004, "R8 read ofs");
    rd(16'h000C, "R8 status unchanged");
    rd(port_addr(0), "R8 ctrl unchanged");

    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic [15:0] a;
      logic [N-1:0] ak;
      logic [2*N-1:0] ake;
      int pick;
      pick = int'($urandom % 8);
      if (pick < 5) a = port_addr(int'($urandom % N));
      else if (pick < 7) a = 16'h000C;
      else a = 16'($urandom);
      rd(a, "R2 R6 random read");
      ak = '0; ake = '0;
      for (int i = 0; i < N; i++) begin
        if ($urandom % 3 == 0) begin
          ak[i] = 1'b1;
          ake[2*i +: 2] = ($urandom % 6 == 0) ? 2'($urandom) : m_req[i];
        end
      end
      if ($urandom % 2 == 0)
        tick(1, port_addr(int'($urandom % N)), 2'($urandom), ak, ake, "R7 random");
      else
        tick(0, a, 2'b0, ak, ake, "R5 random");
      cyc++;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule